// File: doc/BRIEF.md
# DDC1 EDID Serial Transmitter with DDC2 Handover

This block is the display-side sender for the one-way DDC1 link. With no bus clock of its own, it uses the host's vertical sync as the bit clock. Each rising edge of VSYNC moves the serial data line on by one bit slot. The first few VSYNC clocks after power-up are only counted, so that host and display line up. After that, the block reads the 128-byte EDID table through a byte read port and shifts it out in an endless loop.

The block also watches the DDC2 clock line (SCL) the whole time DDC1 is active. When a second falling edge of SCL is seen, the block decides that a DDC2-capable host is present. It releases SDA, raises its mode flag and stops sending until the next reset, so that a separate I2C slave can take over the bus. Both VSYNC and SCL arrive asynchronously and pass through two-flop synchronizers inside the block.

The controller has four states:
- `ST_IDLE`: no VSYNC has been seen yet.
- `ST_INIT`: counting the synchronization clocks.
- `ST_SEND`: serializing the table.
- `ST_DDC2`: handed over, terminal until reset.

The transitions are:
- IDLE→INIT on the first VSYNC rise.
- INIT→SEND on the rise that follows the last init clock.
- Any of IDLE, INIT or SEND→DDC2 when the SCL detector fires.

Top module: `ddc1_edid_tx`

## Requirements
- R1: After reset, `sda_oe` = 0, `mode_ddc2` = 0 and `rd_addr` = 0.
- R2: While no VSYNC rising edge arrives, the block stays idle. SDA stays released and `rd_addr` does not move.
- R3: The first INIT_CLOCKS (default 9) VSYNC rising edges after reset are counted only. SDA stays released (`sda_oe` = 0) during all of them.
- R4: From the next rising edge on, each byte takes 9 bit slots, one per VSYNC rise. In slots 0..7, `sda_oe` = 1 and `sda_out` carries the data byte from bit 7 down to bit 0 (MSB first).
- R5: Slot 8 of every byte is a release slot with `sda_oe` = 0.
- R6: `rd_addr` holds the address of the byte being sent during slots 0..7. It advances by one on entry to slot 8. After the last entry (TABLE_BYTES-1, 127 by default) it wraps to 0, with no gap between passes.
- R7: `sda_out` and `sda_oe` change only as a result of a VSYNC rising edge or the DDC2 handover. While VSYNC is held still, they keep their values.
- R8: A single SCL falling edge leaves DDC1 transmission running. The second SCL falling edge seen in DDC1 mode sets `mode_ddc2` = 1 and `sda_oe` = 0, and both stay that way until reset.
- R9: In DDC2 mode, VSYNC edges have no effect: `rd_addr` is frozen and SDA stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Host vertical sync, asynchronous; its rising edge is the DDC1 bit clock |
| scl_in | input | 1 | DDC2 clock line level, asynchronous, idles high |
| rd_data | input | 8 | Byte returned by the EDID memory for `rd_addr` (combinational read) |
| rd_addr | output | ADDR_W (7) | Address of the EDID byte being sent |
| sda_oe | output | 1 | Drive enable for SDA; 0 releases the line |
| sda_out | output | 1 | Data bit driven onto SDA when enabled |
| mode_ddc2 | output | 1 | 0 = DDC1 transmit mode, 1 = handed over to DDC2 |

## Verification
The bench builds the block with TABLE_BYTES = 8 and keeps INIT_CLOCKS = 9 and DDC2_EDGES = 2. The short table lets the run cross the address wrap twice within a few thousand cycles. The full nine-clock synchronization window and the two-edge handover threshold are still exercised exactly as in the default build. Because the handover fires mid-byte, the test also covers abandoning a partly sent byte.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;
    localparam int DATA_BITS = 8;
    localparam int SLOTS     = DATA_BITS + 1;
    localparam int SLOT_W    = $clog2(SLOTS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_SEND = 2'd2,
        ST_DDC2 = 2'd3
    } tx_state_t;
endpackage

// File: rtl/sync_edge.sv
// Multi-stage synchronizer followed by a single-edge detector.
module sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0,
    parameter bit   RISING  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= RST_VAL;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    generate
        if (RISING) begin : g_rise
            assign evt = chain[STAGES-1] & ~prev;
        end else begin : g_fall
            assign evt = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/ddc2_detect.sv
// Counts DDC2 clock edges while enabled; raises a sticky flag at the threshold.
module ddc2_detect #(
    parameter int EDGES = 2,
    localparam int CNT_W = $clog2(EDGES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_fall,
    output logic seen
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (enable && scl_fall && !seen) begin
            if (cnt == CNT_W'(EDGES - 1)) begin
                seen <= 1'b1;
                cnt  <= CNT_W'(EDGES);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: the edge count never runs past the threshold
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(EDGES));
    // R8: once seen, the flag is held until reset
    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> seen);
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx
    import ddc1_pkg::*;
#(
    parameter int TABLE_BYTES = 128,
    parameter int INIT_CLOCKS = 9,
    parameter int DDC2_EDGES  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(TABLE_BYTES),
    localparam int INIT_W     = $clog2(INIT_CLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              scl_in,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_oe,
    output logic              sda_out,
    output logic              mode_ddc2
);
    tx_state_t         state_q, state_d;
    logic              vs_rise;
    logic              scl_fall;
    logic              ddc2_seen;
    logic [INIT_W-1:0] init_cnt;
    logic [SLOT_W-1:0] slot;
    logic [6:0]        shreg;

    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .RISING(1'b1)) u_vs_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (vsync_in),
        .evt   (vs_rise)
    );

    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .RISING(1'b0)) u_scl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .evt   (scl_fall)
    );

    ddc2_detect #(.EDGES(DDC2_EDGES)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state_q != ST_DDC2),
        .scl_fall (scl_fall),
        .seen     (ddc2_seen)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ddc2_seen) begin
            state_d = ST_DDC2;
        end else begin
            unique case (state_q)
                ST_IDLE: if (vs_rise) state_d = ST_INIT;
                ST_INIT: if (vs_rise && init_cnt == INIT_W'(INIT_CLOCKS)) state_d = ST_SEND;
                ST_SEND: state_d = ST_SEND;
                ST_DDC2: state_d = ST_DDC2;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt  <= '0;
            slot      <= '0;
            shreg     <= '0;
            rd_addr   <= '0;
            sda_oe    <= 1'b0;
            sda_out   <= 1'b1;
            mode_ddc2 <= 1'b0;
        end else if (ddc2_seen || state_q == ST_DDC2) begin
            sda_oe    <= 1'b0;
            sda_out   <= 1'b1;
            mode_ddc2 <= 1'b1;
        end else if (vs_rise) begin
            unique case (state_q)
                ST_IDLE: begin
                    init_cnt <= INIT_W'(1);
                end
                ST_INIT: begin
                    if (init_cnt == INIT_W'(INIT_CLOCKS)) begin
                        slot    <= '0;
                        shreg   <= rd_data[6:0];
                        sda_out <= rd_data[7];
                        sda_oe  <= 1'b1;
                    end else begin
                        init_cnt <= init_cnt + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (slot == SLOT_W'(DATA_BITS - 1)) begin
                        slot    <= SLOT_W'(DATA_BITS);
                        sda_oe  <= 1'b0;
                        sda_out <= 1'b1;
                        rd_addr <= (rd_addr == ADDR_W'(TABLE_BYTES - 1)) ? '0 : rd_addr + 1'b1;
                    end else if (slot == SLOT_W'(DATA_BITS)) begin
                        slot    <= '0;
                        shreg   <= rd_data[6:0];
                        sda_out <= rd_data[7];
                        sda_oe  <= 1'b1;
                    end else begin
                        slot    <= slot + 1'b1;
                        sda_out <= shreg[6];
                        shreg   <= {shreg[5:0], 1'b0};
                        sda_oe  <= 1'b1;
                    end
                end
                ST_DDC2: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R3: released while idle or synchronizing
    assert_release_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_INIT) |-> !sda_oe);
    // R5: the ninth slot of a byte is released
    assert_release_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && slot == SLOT_W'(DATA_BITS)) |-> !sda_oe);
    // R6: the address stays inside the table
    assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr <= ADDR_W'(TABLE_BYTES - 1));
    // R7: SDA only moves on a VSYNC rise or a handover
    assert_sda_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_rise && !ddc2_seen) |=> ($stable(sda_out) && $stable(sda_oe)));
    // R8: the mode flag is sticky
    assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ddc2 |=> mode_ddc2);
    // R9: nothing is driven and the address is frozen in DDC2 mode
    assert_ddc2_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ddc2 |=> (!sda_oe && $stable(rd_addr)));
endmodule

// File: tb/sim_ddc1_edid_tx.sv
`timescale 1ns/1ps
module sim_ddc1_edid_tx;
    localparam int TB_BYTES = 8;
    localparam int TB_AW    = $clog2(TB_BYTES);
    localparam int INIT_N   = 9;

    // Per-slot expectation: {drive enable, bit index}
    localparam logic [3:0] SLOT_VEC [0:8] = '{
        4'b1111, 4'b1110, 4'b1101, 4'b1100,
        4'b1011, 4'b1010, 4'b1001, 4'b1000, 4'b0000
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vsync_in = 1'b0;
    logic             scl_in = 1'b1;
    logic [7:0]       rd_data;
    logic [TB_AW-1:0] rd_addr;
    logic             sda_oe, sda_out, mode_ddc2;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    function automatic logic [7:0] mem(input int a);
        return 8'((a * 59 + 165) ^ (a << 4));
    endfunction

    assign rd_data = mem(int'(rd_addr));

    always #4 clk = ~clk;

    ddc1_edid_tx #(.TABLE_BYTES(TB_BYTES), .INIT_CLOCKS(INIT_N), .DDC2_EDGES(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync_in  (vsync_in),
        .scl_in    (scl_in),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .sda_oe    (sda_oe),
        .sda_out   (sda_out),
        .mode_ddc2 (mode_ddc2)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic vs_pulse();
        vsync_in = 1'b1;
        repeat (4) @(posedge clk);
        vsync_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic scl_fall_pulse();
        scl_in = 1'b0;
        repeat (4) @(posedge clk);
        scl_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vsync_in = 1'b0;
        scl_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic hold_oe, hold_sda;
        logic [TB_AW-1:0] hold_addr;

        do_reset();
        chk("R1 oe", int'(sda_oe), 0);
        chk("R1 mode", int'(mode_ddc2), 0);
        chk("R1 addr", int'(rd_addr), 0);

        // R2: no VSYNC, nothing moves
        repeat (200) @(posedge clk);
        @(negedge clk);
        chk("R2 oe", int'(sda_oe), 0);
        chk("R2 addr", int'(rd_addr), 0);

        // R3: synchronization clocks keep SDA released
        for (int i = 0; i < INIT_N; i++) begin
            vs_pulse();
            chk("R3 oe", int'(sda_oe), 0);
            chk("R3 addr", int'(rd_addr), 0);
        end

        // R4 R5 R6: table walk across two wraps
        for (int b = 0; b < 2 * TB_BYTES + 2; b++) begin
            for (int s = 0; s < 9; s++) begin
                logic [7:0] byte_exp;
                vs_pulse();
                byte_exp = mem(b % TB_BYTES);
                if (SLOT_VEC[s][3]) begin
                    chk("R4 oe", int'(sda_oe), 1);
                    chk("R4 bit", int'(sda_out), int'(byte_exp[SLOT_VEC[s][2:0]]));
                    chk("R6 addr", int'(rd_addr), b % TB_BYTES);
                end else begin
                    chk("R5 oe", int'(sda_oe), 0);
                    chk("R6 addr next", int'(rd_addr), (b + 1) % TB_BYTES);
                end
            end
        end

        // R7: VSYNC held still mid-byte
        vs_pulse();
        vs_pulse();
        vs_pulse();
        hold_oe = sda_oe;
        hold_sda = sda_out;
        hold_addr = rd_addr;
        repeat (120) @(posedge clk);
        @(negedge clk);
        chk("R7 oe", int'(sda_oe), int'(hold_oe));
        chk("R7 sda", int'(sda_out), int'(hold_sda));
        chk("R7 addr", int'(rd_addr), int'(hold_addr));

        // R8: one SCL edge does not switch modes
        scl_fall_pulse();
        chk("R8 single mode", int'(mode_ddc2), 0);
        vs_pulse();
        chk("R8 single oe", int'(sda_oe), 1);
        chk("R8 single bit", int'(sda_out), int'(mem(2)[4]));

        // R8: second SCL edge hands over
        scl_fall_pulse();
        chk("R8 mode", int'(mode_ddc2), 1);
        chk("R8 oe", int'(sda_oe), 0);
        hold_addr = rd_addr;

        // R9: VSYNC ignored in DDC2 mode
        for (int i = 0; i < 20; i++) vs_pulse();
        chk("R9 oe", int'(sda_oe), 0);
        chk("R9 addr", int'(rd_addr), int'(hold_addr));
        chk("R9 mode", int'(mode_ddc2), 1);

        // R1: reset leaves DDC2 mode
        do_reset();
        chk("R1 mode after reset", int'(mode_ddc2), 0);
        chk("R1 addr after reset", int'(rd_addr), 0);
        for (int i = 0; i < INIT_N; i++) vs_pulse();
        vs_pulse();
        chk("R4 restart oe", int'(sda_oe), 1);
        chk("R4 restart bit", int'(sda_out), int'(mem(0)[7]));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule